// File: doc/BRIEF.md
# Signed 16x16 Booth-Wallace Multiplier

This block multiplies two 16-bit two's-complement operands and returns the exact 32-bit two's-complement product. It is built structurally rather than from a behavioural `*`. Radix-4 Booth recoding of the multiplier turns the operands into eight partial-product rows. A correction row carries the negation bits and a precomputed sign-extension constant. A tree of row-wide 4:2 compressors reduces the nine rows to two. A reduced three-input (pseudo) 4:2 stage absorbs the odd row. A carry-select adder then resolves the last two rows. Its block widths grow roughly with the square root of the word length.

The parameter `PIPE` sets the timing. With `PIPE = 1`, the default, a register sits between the compressor tree and the final adder. The product is then valid one clock after the operands are presented with `in_valid` high, and `out_valid` marks that cycle. With `PIPE = 0` the whole path is combinational and `out_valid` simply mirrors `in_valid`.

Top module: `booth_wallace_mul`

## Requirements
- R1: For every pair of 16-bit signed operands, `product` equals their exact 32-bit two's-complement product.
- R2: The most negative operand is handled exactly: -32768 x -32768 gives 0x40000000, and -32768 x 1 gives 0xFFFF8000.
- R3: Each radix-4 digit is taken from multiplier bits (b[2i+1], b[2i], b[2i-1]) with b[-1] = 0, and selects 0, +A, +2A, -A or -2A. Multipliers made of repeated digit patterns (0x5555, 0xAAAA, 0xFFFF, 0x8000, 0x7FFF) therefore give exact products.
- R4: Each compression level preserves the arithmetic sum of its input rows modulo 2^32, so the two rows leaving the tree add up to the product.
- R5: The final adder returns the modulo 2^32 sum of the two tree rows, including results whose carry must ripple across every select block (for example -1 x 1 = 0xFFFFFFFF and -1 x -1 = 1).
- R6: With `PIPE = 1`, operands sampled on a rising edge with `in_valid` high appear on `product` after that edge, with one cycle of latency, and a new operand pair may be accepted on every cycle.
- R7: With `PIPE = 1`, `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high, and low otherwise.
- R8: With `PIPE = 1`, while `in_valid` is low the operands are ignored and `product` keeps its last value.
- R9: A synchronous active-low reset drives `out_valid` to 0 and `product` to 0, whatever the operands and `in_valid` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional pipeline register |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are to be multiplied |
| op_a | input | 16 | Multiplicand, two's complement |
| op_b | input | 16 | Multiplier, two's complement, Booth recoded |
| out_valid | output | 1 | `product` holds a fresh result |
| product | output | 32 | Signed product, two's complement |

## Verification
Most internal faults show up at the ports on the very next sampled result, because each one corrupts specific bit columns:
- A wrong Booth select or negation bit corrupts a product whose multiplier contains the affected digit.
- A broken compressor carry shifts weight between columns.
- A wrong select carry spoils only results whose carry crosses that block boundary.

The directed operands are therefore chosen to cover:
- each digit pattern;
- the most negative operand;
- results with full-length carry chains.

A random sweep covers mixed digits. Pipeline and valid faults are exposed one cycle after a change of `in_valid`, by checking streamed, held and reset results.

// File: rtl/bwm_pkg.sv
// Shared widths, row type and constant helpers for the Booth-Wallace multiplier.
// Assumes an even operand width; the reduction tree in the top is laid out
// for exactly OP_W/2 + 1 = 9 rows.
package bwm_pkg;

    localparam int OP_W     = 16;
    localparam int PROD_W   = 2 * OP_W;
    localparam int NUM_PP   = OP_W / 2;
    localparam int PP_W     = OP_W + 2;      // magnitude up to 2A plus sign
    localparam int NUM_BLK  = 8;             // carry-select blocks

    typedef logic [PROD_W-1:0] row_t;

    // Width rule before the last block: 2,2,3,4,5,6,7
    function automatic int blk_rule(input int k);
        return (k == 0) ? 2 : k + 1;
    endfunction

    // Bit offset of carry-select block k
    function automatic int blk_offset(input int k);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) acc += blk_rule(j);
        return acc;
    endfunction

    // Width of carry-select block k; the last block takes the remainder
    function automatic int blk_width(input int k);
        if (k == NUM_BLK - 1) return PROD_W - blk_offset(k);
        return blk_rule(k);
    endfunction

    // Negated sum of the sign-extension weights 2^(PP_W+2i), modulo 2^PROD_W
    function automatic row_t sext_const();
        row_t acc;
        acc = '0;
        for (int i = 0; i < NUM_PP; i++) acc = acc + (row_t'(1) << (PP_W + 2 * i));
        return (~acc) + row_t'(1);
    endfunction

endpackage

// File: rtl/bwm_booth_pp.sv
// Radix-4 Booth partial-product generator.
// Each row i is {~sign, pp[PP_W-1:0]} shifted left by 2i, where pp is the
// one's complement of the selected multiple when the digit is negative.
// The correction row holds the +1 negation bits at weight 2i and the
// constant that replaces full sign extension. Purely combinational.
module bwm_booth_pp
    import bwm_pkg::*;
(
    input  logic [OP_W-1:0]              mcand,
    input  logic [OP_W-1:0]              mplier,
    output logic [NUM_PP-1:0][PROD_W-1:0] pp_rows,
    output row_t                          corr_row
);

    localparam row_t SEXT_K = sext_const();

    logic [OP_W:0]      b_ext;
    logic [PP_W-1:0]    mult_one;
    logic [PP_W-1:0]    mult_two;
    logic [NUM_PP-1:0]  neg_bits;

    assign b_ext    = {mplier, 1'b0};
    assign mult_one = {{2{mcand[OP_W-1]}}, mcand};
    assign mult_two = {mcand[OP_W-1], mcand, 1'b0};

    for (genvar gi = 0; gi < NUM_PP; gi++) begin : g_digit
        logic [2:0]      grp;
        logic            sel_one;
        logic            sel_two;
        logic [PP_W-1:0] mag;
        logic [PP_W-1:0] pp;

        assign grp = b_ext[2*gi+2 -: 3];

        // Decode the Booth digit into magnitude selects and sign
        always_comb begin
            sel_one = grp[1] ^ grp[0];
            sel_two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
            mag     = sel_one ? mult_one : (sel_two ? mult_two : '0);
            pp      = mag ^ {PP_W{grp[2]}};
        end

        assign pp_rows[gi]  = PROD_W'({~pp[PP_W-1], pp}) << (2 * gi);
        assign neg_bits[gi] = grp[2];
    end

    // Merge negation bits with the sign-extension constant (disjoint columns)
    always_comb begin
        corr_row = SEXT_K;
        for (int i = 0; i < NUM_PP; i++) corr_row[2*i] = neg_bits[i];
    end

endmodule

// File: rtl/bwm_c42_row.sv
// Row-wide 4:2 compressor: four rows in, sum and carry rows out.
// Column j: a full adder on in0..in2 gives s1 and cout; a second full adder
// adds s1, in3 and the cout of column j-1. cout never depends on the
// incoming carry, so there is no ripple across the row. Sums are modulo 2^PROD_W.
module bwm_c42_row
    import bwm_pkg::*;
(
    input  row_t in0,
    input  row_t in1,
    input  row_t in2,
    input  row_t in3,
    output row_t sum_o,
    output row_t carry_o
);

    row_t s1, co, cin, c2;

    // First full-adder layer on three of the rows
    always_comb begin
        s1 = in0 ^ in1 ^ in2;
        co = (in0 & in1) | (in0 & in2) | (in1 & in2);
    end

    assign cin = {co[PROD_W-2:0], 1'b0};

    // Second full-adder layer folds in the fourth row and the lateral carry
    always_comb begin
        sum_o = s1 ^ in3 ^ cin;
        c2    = (s1 & in3) | (s1 & cin) | (in3 & cin);
    end

    assign carry_o = {c2[PROD_W-2:0], 1'b0};

endmodule

// File: rtl/bwm_p42_row.sv
// Pseudo 4:2 compressor row for a level with only three rows.
// The full adder on the three inputs is kept; with the fourth input absent,
// the second stage reduces to a half adder of s1 and the lateral carry.
module bwm_p42_row
    import bwm_pkg::*;
(
    input  row_t in0,
    input  row_t in1,
    input  row_t in2,
    output row_t sum_o,
    output row_t carry_o
);

    row_t s1, co, cin, c2;

    // Full-adder layer on the three rows
    always_comb begin
        s1 = in0 ^ in1 ^ in2;
        co = (in0 & in1) | (in0 & in2) | (in1 & in2);
    end

    assign cin = {co[PROD_W-2:0], 1'b0};

    // Half-adder layer with the lateral carry
    always_comb begin
        sum_o = s1 ^ cin;
        c2    = s1 & cin;
    end

    assign carry_o = {c2[PROD_W-2:0], 1'b0};

endmodule

// File: rtl/bwm_csel_adder.sv
// Square-root carry-select adder, modulo 2^PROD_W, carry-in zero.
// Block widths come from bwm_pkg (2,2,3,4,5,6,7,3). The first block adds
// directly. Each later block forms both sums, for carry-in 0 and 1, and the
// carry out of the previous block picks one. The last block drops its carry out.
module bwm_csel_adder
    import bwm_pkg::*;
(
    input  row_t x,
    input  row_t y,
    output row_t total
);

    logic [NUM_BLK-1:1] blk_cin;

    for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
        localparam int OFF = blk_offset(k);
        localparam int W   = blk_width(k);

        if (k == 0) begin : g_first
            logic [W:0] s0;
            assign s0                = {1'b0, x[OFF +: W]} + {1'b0, y[OFF +: W]};
            assign total[OFF +: W]   = s0[W-1:0];
            assign blk_cin[1]        = s0[W];
        end else if (k == NUM_BLK - 1) begin : g_last
            logic [W-1:0] s0, s1;
            assign s0              = x[OFF +: W] + y[OFF +: W];
            assign s1              = x[OFF +: W] + y[OFF +: W] + W'(1);
            assign total[OFF +: W] = blk_cin[k] ? s1 : s0;
        end else begin : g_mid
            logic [W:0] s0, s1;
            assign s0              = {1'b0, x[OFF +: W]} + {1'b0, y[OFF +: W]};
            assign s1              = {1'b0, x[OFF +: W]} + {1'b0, y[OFF +: W]} + (W+1)'(1);
            assign total[OFF +: W] = blk_cin[k] ? s1[W-1:0] : s0[W-1:0];
            assign blk_cin[k+1]    = blk_cin[k] ? s1[W] : s0[W];
        end
    end

endmodule

// File: rtl/booth_wallace_mul.sv
// Signed 16x16 multiplier: Booth radix-4 rows, 4:2 compressor tree
// (9 -> 4+1 -> 2+1 -> 2 rows), optional register after the tree, and a
// square-root carry-select final adder. PIPE=1 gives one cycle of latency;
// PIPE=0 is fully combinational with out_valid following in_valid directly.
module booth_wallace_mul
    import bwm_pkg::*;
#(
    parameter bit PIPE = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic              out_valid,
    output logic [PROD_W-1:0] product
);

    logic [NUM_PP-1:0][PROD_W-1:0] pp_rows;
    row_t corr_row;
    row_t l1_s [2];
    row_t l1_c [2];
    row_t l2_s, l2_c;
    row_t tree_s, tree_c;
    row_t add_x, add_y;

    bwm_booth_pp u_pp (
        .mcand    (op_a),
        .mplier   (op_b),
        .pp_rows  (pp_rows),
        .corr_row (corr_row)
    );

    // Level 1: two 4:2 rows on partial products 0-3 and 4-7
    for (genvar g = 0; g < 2; g++) begin : g_lvl1
        bwm_c42_row u_c42 (
            .in0     (pp_rows[4*g]),
            .in1     (pp_rows[4*g+1]),
            .in2     (pp_rows[4*g+2]),
            .in3     (pp_rows[4*g+3]),
            .sum_o   (l1_s[g]),
            .carry_o (l1_c[g])
        );
    end

    // Level 2: 4:2 on the four level-1 rows
    bwm_c42_row u_lvl2 (
        .in0     (l1_s[0]),
        .in1     (l1_c[0]),
        .in2     (l1_s[1]),
        .in3     (l1_c[1]),
        .sum_o   (l2_s),
        .carry_o (l2_c)
    );

    // Level 3: pseudo 4:2 folds in the correction row
    bwm_p42_row u_lvl3 (
        .in0     (l2_s),
        .in1     (l2_c),
        .in2     (corr_row),
        .sum_o   (tree_s),
        .carry_o (tree_c)
    );

    if (PIPE) begin : g_pipe
        row_t tree_s_q, tree_c_q;
        logic vld_q;

        // Capture the tree rows on accepted operands; hold otherwise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tree_s_q <= '0;
                tree_c_q <= '0;
            end else if (in_valid) begin
                tree_s_q <= tree_s;
                tree_c_q <= tree_c;
            end
        end

        // Delay the valid flag by one cycle
        always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= 1'b0;
            else        vld_q <= in_valid;
        end

        assign add_x     = tree_s_q;
        assign add_y     = tree_c_q;
        assign out_valid = vld_q;

        // Behavioural reference used only by the assertions below
        logic signed [PROD_W-1:0] ref_a, ref_b, ref_prod;
        assign ref_a    = $signed(op_a);
        assign ref_b    = $signed(op_b);
        assign ref_prod = ref_a * ref_b;

        a_r4_tree_sum: assert property (@(posedge clk) disable iff (!rst_n)
            (tree_s + tree_c) == ref_prod);
        a_r5_final_add: assert property (@(posedge clk) disable iff (!rst_n)
            product == tree_s_q + tree_c_q);
        a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_valid && product == $past(ref_prod)));
        a_r7_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(product));
    end else begin : g_comb
        assign add_x     = tree_s;
        assign add_y     = tree_c;
        assign out_valid = in_valid;
    end

    bwm_csel_adder u_add (
        .x     (add_x),
        .y     (add_y),
        .total (product)
    );

endmodule

// File: tb/booth_wallace_mul_test.sv
module booth_wallace_mul_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        out_valid;
    logic [31:0] product;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    booth_wallace_mul #(.PIPE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
    );

    function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] ea, eb;
        ea = $signed(a);
        eb = $signed(b);
        return ea * eb;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one operand pair, then check valid and product one cycle later
    task automatic mul_check(input string req, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        check(req, "out_valid", {31'b0, out_valid}, 32'd1);
        check(req, $sformatf("%h*%h", a, b), product, ref_mul(a, b));
    endtask

    task automatic t_reset();   // R9
        rst_n = 1'b0; in_valid = 1'b1; op_a = 16'h1234; op_b = 16'h4321;
        repeat (3) @(negedge clk);
        check("R9", "out_valid in reset", {31'b0, out_valid}, 32'd0);
        check("R9", "product in reset", product, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R9", "out_valid after reset", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_corners();   // R2
        mul_check("R2", 16'h8000, 16'h8000);
        check("R2", "min*min literal", product, 32'h4000_0000);
        mul_check("R2", 16'h8000, 16'h0001);
        check("R2", "min*1 literal", product, 32'hFFFF_8000);
        mul_check("R2", 16'h8000, 16'h7FFF);
        mul_check("R2", 16'h7FFF, 16'h8000);
        mul_check("R2", 16'h8000, 16'hFFFF);
    endtask

    task automatic t_digits();   // R3
        logic [15:0] pats [6] = '{16'h5555, 16'hAAAA, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001};
        foreach (pats[i]) begin
            mul_check("R3", 16'h1357, pats[i]);
            mul_check("R3", 16'hC0DE, pats[i]);
        end
    endtask

    task automatic t_carry();   // R5
        mul_check("R5", 16'hFFFF, 16'h0001);
        check("R5", "-1*1 literal", product, 32'hFFFF_FFFF);
        mul_check("R5", 16'hFFFF, 16'hFFFF);
        check("R5", "-1*-1 literal", product, 32'h0000_0001);
        mul_check("R5", 16'h7FFF, 16'h7FFF);
        mul_check("R5", 16'h00FF, 16'h0101);
        mul_check("R5", 16'h0000, 16'h8000);
    endtask

    task automatic t_random();   // R1, R4
        for (int n = 0; n < 1500; n++)
            mul_check("R1", 16'($urandom), 16'($urandom));
    endtask

    task automatic t_stream();   // R6, R7: back-to-back pairs then a drop of in_valid
        for (int n = 0; n < 6; n++) mul_check("R6", 16'(n * 1111 - 3000), 16'(7 - n * 2345));
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R7", "out_valid after idle", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_hold();   // R8
        logic [31:0] held;
        mul_check("R8", 16'h0123, 16'h0456);
        held = product;
        @(negedge clk);
        in_valid = 1'b0; op_a = 16'h7777; op_b = 16'h9999;
        repeat (3) @(negedge clk);
        check("R8", "product held", product, held);
        check("R8", "out_valid held low", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 100000 cycles expected completion earlier");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_corners();
        t_digits();
        t_carry();
        t_stream();
        t_hold();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule